// File: doc/BRIEF.md
# DDR4 Bank State Tracker

This block follows the state of every bank in a DDR4 device as the memory controller issues commands. It watches the registered command and address inputs each cycle and acts on four command kinds: ACTIVATE, READ, WRITE and PRECHARGE. For every bank it keeps two things: whether the bank holds an open row, and which row that is. A parameter sets the device width. The width decides how the bank-group and bank bits combine into a bank index.

For each READ or WRITE it first checks that the target bank is open. If so, it reports the following one cycle later:
- the starting column;
- whether auto-precharge was requested;
- the resulting burst length;
- the number of clocks the data transfer takes.

Any command that breaks the bank rules raises a one-cycle error pulse and leaves the bank state unchanged. The block also gives a per-bank open vector, an open-row lookup port and an all-idle flag. Power-down entry logic can use the all-idle flag to choose between precharge and active power-down.

Top module: `ddr4bt_tracker`

## Requirements
- R1: The bank index is {bg_i[1], bg_i[0], ba_i[1], ba_i[0]} (16 banks) when DEV_W is 4 or 8. When DEV_W is 16 it is {bg_i[0], ba_i[1], ba_i[0]} (8 banks), and bg_i[1] is ignored.
- R2: An ACTIVATE (cmd_i = 1) to a closed bank opens it and records addr_i[17:0] as its row. From the next cycle, bank_open_o shows the bank open, and lookup_open_o / lookup_row_o show that row for that bank.
- R3: An ACTIVATE to an open bank pulses err_o in the next cycle and leaves the bank open with its recorded row unchanged.
- R4: A READ (cmd_i = 2) or WRITE (cmd_i = 3) to a closed bank pulses err_o in the next cycle. It does not raise acc_valid_o and changes no bank state.
- R5: A READ or WRITE to an open bank raises acc_valid_o for one cycle in the next cycle, with these values:
  - acc_col_o = addr_i[9:0];
  - acc_wr_o = 1 for WRITE and 0 for READ;
  - acc_ap_o = addr_i[10].
  err_o and acc_valid_o are never high together.
- R6: A legal READ or WRITE with addr_i[10] = 1 closes its bank, so the bank shows closed in the next cycle. With addr_i[10] = 0 the bank stays open.
- R7: When otf_en_i = 1, addr_i[12] = 1 gives acc_bl_o = 8 and addr_i[12] = 0 gives acc_bl_o = 4. When otf_en_i = 0, acc_bl_o is 4 if cfg_bc4_i = 1 and 8 otherwise. acc_clks_o is always acc_bl_o / 2, because two words move per clock.
- R8: A PRECHARGE (cmd_i = 4) with addr_i[10] = 1 closes every bank. With addr_i[10] = 0 it closes only the addressed bank. A PRECHARGE never raises err_o, even to a closed bank.
- R9: all_idle_o is high exactly when no bank is open.
- R10: After reset all banks are closed, all_idle_o is high, and err_o and acc_valid_o are low. Command code 0 (no operation) and codes 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| otf_en_i | input | 1 | Burst length picked per access from addr_i[12] |
| cfg_bc4_i | input | 1 | Fixed burst of 4 when on-the-fly mode is off |
| cmd_i | input | 3 | Command code: 0 none, 1 activate, 2 read, 3 write, 4 precharge |
| bg_i | input | 2 | Bank-group bits |
| ba_i | input | 2 | Bank bits |
| addr_i | input | 18 | Row address, or column plus control bits |
| lookup_bank_i | input | BANK_W | Bank to look up |
| bank_open_o | output | NB | One bit per bank, high when open |
| lookup_open_o | output | 1 | Looked-up bank is open |
| lookup_row_o | output | 18 | Open row of the looked-up bank |
| all_idle_o | output | 1 | No bank open |
| err_o | output | 1 | Illegal command seen in the previous cycle |
| acc_valid_o | output | 1 | Legal access seen in the previous cycle |
| acc_wr_o | output | 1 | That access was a write |
| acc_col_o | output | 10 | Starting column |
| acc_ap_o | output | 1 | Auto-precharge requested |
| acc_bl_o | output | 4 | Burst length, 4 or 8 |
| acc_clks_o | output | 3 | Clocks of data transfer, 2 or 4 |

## Verification
The assertions assume that cmd_i, bg_i, ba_i and addr_i are sampled values that are stable at the clock edge. They also assume that no command other than the five codes carries meaning. The properties compare each command with the bank state the block exposes. The stimulus therefore needs no legality filter: it draws commands with weights from a fixed seed and includes every illegal case on purpose. It uses a narrow bank range, so activates often hit open banks and accesses often hit closed ones. One bench model serves both width variants, which share the same inputs. In the 16-bank variant bg_i[1] is driven at random, and the 8-bank variant must ignore it.

// File: rtl/ddr4bt_pkg.sv
package ddr4bt_pkg;
    localparam int ROW_W  = 18;
    localparam int COL_W  = 10;
    localparam int AP_BIT = 10;
    localparam int BC_BIT = 12;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } cmd_e;

    function automatic int bank_count(input int dev_w);
        return (dev_w == 16) ? 8 : 16;
    endfunction
endpackage

// File: rtl/ddr4bt_bank_sel.sv
module ddr4bt_bank_sel #(
    parameter int DEV_W  = 8,
    parameter int BANK_W = 4
) (
    input  logic [1:0]        bg_i,
    input  logic [1:0]        ba_i,
    output logic [BANK_W-1:0] idx_o
);
    generate
        if (DEV_W == 16) begin : g_x16
            // two groups of four; upper group bit unused
            assign idx_o = {bg_i[0], ba_i};
        end else begin : g_x4x8
            assign idx_o = {bg_i, ba_i};
        end
    endgenerate
endmodule

// File: rtl/ddr4bt_burst_dec.sv
module ddr4bt_burst_dec (
    input  logic       otf_en_i,
    input  logic       cfg_bc4_i,
    input  logic       a12_i,
    output logic [3:0] bl_o,
    output logic [2:0] clks_o
);
    logic chop;
    always_comb begin
        chop   = otf_en_i ? ~a12_i : cfg_bc4_i;
        bl_o   = chop ? 4'd4 : 4'd8;
        clks_o = chop ? 3'd2 : 3'd4;
    end
endmodule

// File: rtl/ddr4bt_tracker.sv
module ddr4bt_tracker
    import ddr4bt_pkg::*;
#(
    parameter int DEV_W  = 8,
    parameter int NB     = bank_count(DEV_W),
    parameter int BANK_W = $clog2(NB)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 otf_en_i,
    input  logic                 cfg_bc4_i,
    input  logic [2:0]           cmd_i,
    input  logic [1:0]           bg_i,
    input  logic [1:0]           ba_i,
    input  logic [ROW_W-1:0]     addr_i,
    input  logic [BANK_W-1:0]    lookup_bank_i,
    output logic [NB-1:0]        bank_open_o,
    output logic                 lookup_open_o,
    output logic [ROW_W-1:0]     lookup_row_o,
    output logic                 all_idle_o,
    output logic                 err_o,
    output logic                 acc_valid_o,
    output logic                 acc_wr_o,
    output logic [COL_W-1:0]     acc_col_o,
    output logic                 acc_ap_o,
    output logic [3:0]           acc_bl_o,
    output logic [2:0]           acc_clks_o
);
    typedef struct packed {
        logic [NB-1:0]            open;
        logic [NB-1:0][ROW_W-1:0] row;
        logic                     err;
        logic                     acc_v;
        logic                     acc_wr;
        logic [COL_W-1:0]         col;
        logic                     ap;
        logic [3:0]               bl;
        logic [2:0]               clks;
    } st_t;

    st_t st_d, st_q;

    logic [BANK_W-1:0] sel_idx;
    logic [3:0]        dec_bl;
    logic [2:0]        dec_clks;

    ddr4bt_bank_sel #(.DEV_W(DEV_W), .BANK_W(BANK_W)) u_sel (
        .bg_i  (bg_i),
        .ba_i  (ba_i),
        .idx_o (sel_idx)
    );

    ddr4bt_burst_dec u_bl (
        .otf_en_i  (otf_en_i),
        .cfg_bc4_i (cfg_bc4_i),
        .a12_i     (addr_i[BC_BIT]),
        .bl_o      (dec_bl),
        .clks_o    (dec_clks)
    );

    always_comb begin
        st_d       = st_q;
        st_d.err   = 1'b0;
        st_d.acc_v = 1'b0;
        case (cmd_i)
            CMD_ACT: begin
                if (st_q.open[sel_idx]) begin
                    st_d.err = 1'b1;
                end else begin
                    st_d.open[sel_idx] = 1'b1;
                    st_d.row[sel_idx]  = addr_i;
                end
            end
            CMD_RD, CMD_WR: begin
                if (!st_q.open[sel_idx]) begin
                    st_d.err = 1'b1;
                end else begin
                    st_d.acc_v  = 1'b1;
                    st_d.acc_wr = (cmd_i == CMD_WR);
                    st_d.col    = addr_i[COL_W-1:0];
                    st_d.ap     = addr_i[AP_BIT];
                    st_d.bl     = dec_bl;
                    st_d.clks   = dec_clks;
                    if (addr_i[AP_BIT]) st_d.open[sel_idx] = 1'b0;
                end
            end
            CMD_PRE: begin
                if (addr_i[AP_BIT]) st_d.open = '0;
                else                st_d.open[sel_idx] = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bank_open_o   = st_q.open;
    assign lookup_open_o = st_q.open[lookup_bank_i];
    assign lookup_row_o  = st_q.row[lookup_bank_i];
    assign all_idle_o    = ~|st_q.open;
    assign err_o         = st_q.err;
    assign acc_valid_o   = st_q.acc_v;
    assign acc_wr_o      = st_q.acc_wr;
    assign acc_col_o     = st_q.col;
    assign acc_ap_o      = st_q.ap;
    assign acc_bl_o      = st_q.bl;
    assign acc_clks_o    = st_q.clks;
endmodule

// File: rtl/ddr4bt_chk.sv
module ddr4bt_chk #(
    parameter int NB     = 16,
    parameter int BANK_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              otf_en_i,
    input logic [2:0]        cmd_i,
    input logic [17:0]       addr_i,
    input logic [BANK_W-1:0] idx,
    input logic [NB-1:0]     bank_open_o,
    input logic              all_idle_o,
    input logic              err_o,
    input logic              acc_valid_o,
    input logic [3:0]        acc_bl_o
);
    logic is_acc;
    assign is_acc = (cmd_i == 3'd2) || (cmd_i == 3'd3);

    // R2
    act_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd1 && !bank_open_o[idx]) |=> (bank_open_o[$past(idx)] && !err_o));

    // R3
    act_twice_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd1 && bank_open_o[idx]) |=> (err_o && bank_open_o[$past(idx)]));

    // R4
    acc_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_acc && !bank_open_o[idx]) |=> (err_o && !acc_valid_o));

    // R5
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_o && acc_valid_o));

    // R6
    ap_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_acc && bank_open_o[idx] && addr_i[10]) |=> (acc_valid_o && !bank_open_o[$past(idx)]));

    // R7
    otf_bl8_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_acc && bank_open_o[idx] && otf_en_i && addr_i[12]) |=> (acc_bl_o == 4'd8));

    // R8
    pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd4 && addr_i[10]) |=> (all_idle_o && !err_o));
endmodule

bind ddr4bt_tracker ddr4bt_chk #(.NB(NB), .BANK_W(BANK_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .otf_en_i    (otf_en_i),
    .cmd_i       (cmd_i),
    .addr_i      (addr_i),
    .idx         (sel_idx),
    .bank_open_o (bank_open_o),
    .all_idle_o  (all_idle_o),
    .err_o       (err_o),
    .acc_valid_o (acc_valid_o),
    .acc_bl_o    (acc_bl_o)
);

// File: tb/ddr4bt_tracker_tb.sv
module ddr4bt_tracker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        otf = 1'b0, bc4 = 1'b0;
    logic [2:0]  cmd = 3'd0;
    logic [1:0]  bg = 2'd0, ba = 2'd0;
    logic [17:0] addr = '0;
    logic [3:0]  lk = 4'd0;

    logic [15:0] o_open8;  logic [7:0] o_open16;
    logic [17:0] o_row [2];
    logic        o_lko [2], o_idle [2], o_err [2], o_v [2], o_wr [2], o_ap [2];
    logic [9:0]  o_col [2];
    logic [3:0]  o_bl [2];
    logic [2:0]  o_clks [2];

    int nchk = 0, nerr = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ddr4bt_tracker #(.DEV_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .otf_en_i(otf), .cfg_bc4_i(bc4), .cmd_i(cmd),
        .bg_i(bg), .ba_i(ba), .addr_i(addr), .lookup_bank_i(lk),
        .bank_open_o(o_open8), .lookup_open_o(o_lko[0]), .lookup_row_o(o_row[0]),
        .all_idle_o(o_idle[0]), .err_o(o_err[0]), .acc_valid_o(o_v[0]), .acc_wr_o(o_wr[0]),
        .acc_col_o(o_col[0]), .acc_ap_o(o_ap[0]), .acc_bl_o(o_bl[0]), .acc_clks_o(o_clks[0]));

    ddr4bt_tracker #(.DEV_W(16)) u_dut_x16 (
        .clk(clk), .rst_n(rst_n), .otf_en_i(otf), .cfg_bc4_i(bc4), .cmd_i(cmd),
        .bg_i(bg), .ba_i(ba), .addr_i(addr), .lookup_bank_i(lk[2:0]),
        .bank_open_o(o_open16), .lookup_open_o(o_lko[1]), .lookup_row_o(o_row[1]),
        .all_idle_o(o_idle[1]), .err_o(o_err[1]), .acc_valid_o(o_v[1]), .acc_wr_o(o_wr[1]),
        .acc_col_o(o_col[1]), .acc_ap_o(o_ap[1]), .acc_bl_o(o_bl[1]), .acc_clks_o(o_clks[1]));

    // bench model: [0] = 16-bank variant, [1] = 8-bank variant
    logic        m_open [2][16];
    logic [17:0] m_row  [2][16];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int nbanks(input int k);
        return (k == 0) ? 16 : 8;
    endfunction

    function automatic int bidx(input int k, input logic [1:0] g, input logic [1:0] b);
        return (k == 0) ? int'({g, b}) : int'({g[0], b});
    endfunction

    function automatic logic [3:0] exp_bl(input logic o, input logic c, input logic a12);
        if (o) return a12 ? 4'd8 : 4'd4;
        return c ? 4'd4 : 4'd8;
    endfunction

    task automatic check_state(input int k, input string tag);
        logic [15:0] ev;
        logic [15:0] av;
        int          lb;
        ev = '0;
        for (int i = 0; i < nbanks(k); i++) ev[i] = m_open[k][i];
        av = (k == 0) ? o_open8 : {8'h0, o_open16};
        chk({"R1/R2/R8 bank_open ", tag}, 32'(av), 32'(ev));
        chk({"R9 all_idle ", tag}, 32'(o_idle[k]), 32'(ev == 16'h0));
        lb = (k == 0) ? int'(lk) : int'(lk[2:0]);
        chk({"R2 lookup_open ", tag}, 32'(o_lko[k]), 32'(m_open[k][lb]));
        if (m_open[k][lb]) chk({"R2/R3 lookup_row ", tag}, 32'(o_row[k]), 32'(m_row[k][lb]));
    endtask

    task automatic step(input logic [2:0] c, input logic [1:0] g, input logic [1:0] b,
                        input logic [17:0] a, input logic [3:0] l);
        logic e_err [2];
        logic e_v   [2];
        cmd = c; bg = g; ba = b; addr = a; lk = l;
        for (int k = 0; k < 2; k++) begin
            int ix;
            ix = bidx(k, g, b);
            e_err[k] = 1'b0; e_v[k] = 1'b0;
            case (c)
                3'd1: if (m_open[k][ix]) e_err[k] = 1'b1;
                      else begin m_open[k][ix] = 1'b1; m_row[k][ix] = a; end
                3'd2, 3'd3: if (!m_open[k][ix]) e_err[k] = 1'b1;
                      else begin e_v[k] = 1'b1; if (a[10]) m_open[k][ix] = 1'b0; end
                3'd4: if (a[10]) for (int i = 0; i < 16; i++) m_open[k][i] = 1'b0;
                      else m_open[k][ix] = 1'b0;
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            string t;
            t = (k == 0) ? "x8" : "x16";
            chk({"R3/R4 err ", t}, 32'(o_err[k]), 32'(e_err[k]));
            chk({"R5 acc_valid ", t}, 32'(o_v[k]), 32'(e_v[k]));
            if (e_v[k]) begin
                chk({"R5 col ", t}, 32'(o_col[k]), 32'(a[9:0]));
                chk({"R5 wr ", t}, 32'(o_wr[k]), 32'(c == 3'd3));
                chk({"R5 ap ", t}, 32'(o_ap[k]), 32'(a[10]));
                chk({"R7 bl ", t}, 32'(o_bl[k]), 32'(exp_bl(otf, bc4, a[12])));
                chk({"R7 clks ", t}, 32'(o_clks[k]), 32'(exp_bl(otf, bc4, a[12]) / 2));
            end
            check_state(k, t);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int k = 0; k < 2; k++)
            for (int i = 0; i < 16; i++) begin m_open[k][i] = 1'b0; m_row[k][i] = '0; end
        repeat (3) @(negedge clk);
        // R10 reset state
        for (int k = 0; k < 2; k++) begin
            chk("R10 err after reset", 32'(o_err[k]), 32'h0);
            chk("R10 acc_valid after reset", 32'(o_v[k]), 32'h0);
            chk("R10 all_idle after reset", 32'(o_idle[k]), 32'h1);
        end
        rst_n = 1'b1;
        // R2: open x8 bank 5 / x16 bank 5
        step(3'd1, 2'd1, 2'd1, 18'h2ABCD, 4'd5);
        // R3: second activate errors, row kept
        step(3'd1, 2'd1, 2'd1, 18'h11111, 4'd5);
        // R4: read closed bank
        step(3'd2, 2'd0, 2'd2, 18'h00055, 4'd5);
        // R10: no-op and unused code change nothing
        step(3'd0, 2'd0, 2'd0, 18'h3FFFF, 4'd5);
        step(3'd7, 2'd1, 2'd1, 18'h3FFFF, 4'd5);
        // R7: on-the-fly bl8 then bc4, then fixed modes
        otf = 1'b1;
        step(3'd2, 2'd1, 2'd1, 18'h01123, 4'd5);
        step(3'd3, 2'd1, 2'd1, 18'h00123, 4'd5);
        otf = 1'b0; bc4 = 1'b1;
        step(3'd2, 2'd1, 2'd1, 18'h01007, 4'd5);
        bc4 = 1'b0;
        step(3'd2, 2'd1, 2'd1, 18'h00008, 4'd5);
        // R6: write with auto-precharge closes bank
        step(3'd3, 2'd1, 2'd1, 18'h00420, 4'd5);
        // R1: group 2 bank 1 -> x8 idx 9, x16 idx 1 (bg1 ignored)
        step(3'd1, 2'd2, 2'd1, 18'h0BEEF, 4'd9);
        step(3'd1, 2'd0, 2'd1, 18'h0CAFE, 4'd1);
        step(3'd1, 2'd3, 2'd3, 18'h12345, 4'd15);
        // R8: single precharge, precharge of closed bank, precharge all
        step(3'd4, 2'd2, 2'd1, 18'h00000, 4'd9);
        step(3'd4, 2'd2, 2'd1, 18'h00000, 4'd9);
        step(3'd4, 2'd0, 2'd0, 18'h00400, 4'd15);
        // random mix
        for (int n = 0; n < 600; n++) begin
            int r;
            logic [2:0] c;
            r = $urandom_range(0, 99);
            if (r < 35) c = 3'd1;
            else if (r < 60) c = 3'd2;
            else if (r < 80) c = 3'd3;
            else if (r < 93) c = 3'd4;
            else c = 3'($urandom_range(5, 7)) & ((r & 1) != 0 ? 3'd7 : 3'd0);
            otf = 1'($urandom); bc4 = 1'($urandom);
            step(c, 2'($urandom), 2'($urandom_range(0, 1)), 18'($urandom) & ((r % 5 == 0) ? 18'h3FFFF : 18'h3FBFF),
                 4'($urandom));
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule